// File: doc/BRIEF.md
# Gated I2S Stereo Transmitter

This block is the transmit side of an I2S master for a single left/right channel pair. Software loads a left sample, then a right sample, through a small register port. The second write pushes the pair as one frame into a transmit FIFO. A serializer pops frames and shifts them out on a serial clock, a word-select line and a serial data line. The bit rate comes from an external one-cycle enable pulse (`bclk_en`). Each pulse toggles the serial clock, so the bit clock runs at sample rate × slot width × 2 when the pulse rate is set to match.

Transmission starts only when four separate enable bits are all set. The slot length (serial clocks per word-select half-period) and the sample resolution are programmed independently. A shorter sample is sent MSB-first one bit clock after the word-select edge, and the rest of the slot is filled with zeros. When the FIFO runs dry, zero frames are sent and word-select timing carries on. Two interrupt sources are combined into one maskable line: FIFO level at or below a programmable threshold, and a sticky overrun for a push into a full FIFO. The FIFO can be flushed.

Register map (word addresses on `bus_addr`): 0 control, 1 format, 2 threshold, 3 mask, 4 left holding, 5 right holding, 6 flush, 7 status, 8 overrun clear.

Top module: `i2s_tx_core`

## Requirements
- R1: Serial clock, word select and serial data stay 0 unless control bits 0 (global), 1 (transmitter block), 2 (clock) and 3 (pair transmit) are all 1.
- R2: Format bits [4:3] set the serial clocks per word-select half-period: code 0 gives 16, code 1 gives 24, code 2 gives 32.
- R3: Format bits [2:0] set the sample resolution: code 2 gives 16 bits, code 4 gives 24 bits, code 5 gives 32 bits. The sample is the low bits of the written value.
- R4: Word select 0 carries the left sample and 1 the right. Each sample starts MSB-first one bit clock after the word-select edge, and the slot bits after the sample are 0.
- R5: A write to the left holding register followed by a write to the right one pushes one frame. Frames are transmitted in push order.
- R6: With the FIFO empty while running, a frame of zeros is sent and the slot length is unchanged.
- R7: A right-register write while the FIFO is full drops the frame and sets status bit 5, which stays set until the overrun-clear register is read.
- R8: Status bit 4 is 1 whenever the FIFO level is at or below the threshold register; a threshold of 2 works.
- R9: `irq` is the OR of status bit 4 gated by mask bit 4 clear and status bit 5 gated by mask bit 5 clear. Both mask bits are 1 after reset. `irq` follows one cycle after the status.
- R10: Writing 1 to bit 0 of the flush register empties the FIFO.
- R11: Each `bclk_en` pulse toggles the serial clock, and word select and data change only when the serial clock falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_en | input | 1 | One-cycle pulse; each toggles the serial clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| i2s_sclk | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select, 0 = left |
| i2s_sd | output | 1 | Serial data |
| irq | output | 1 | Combined masked interrupt |

## Verification
Register writes take effect at the next clock edge. Status reads are sampled one cycle later, and `irq` is sampled two cycles after the write, because it is registered from the status. Serial results are taken at every rising serial clock, and each slot is rebuilt bit by bit. A slot is closed only when word select changes, at which point the finished frame is compared against the scoreboard queue, or against zero when the queue is empty. Inputs are driven on the falling system edge and outputs are sampled there, so every check sits at least half a cycle away from the register updates.

// File: rtl/i2s_tx_pkg.sv
// Shared constants, register addresses and field decoders for the I2S transmitter.
package i2s_tx_pkg;

    localparam int unsigned REG_AW = 4;   // register word-address width
    localparam int unsigned LEN_W  = 6;   // holds slot/resolution lengths up to 32

    typedef enum logic [REG_AW-1:0] {
        A_CTRL   = 4'd0,
        A_FMT    = 4'd1,
        A_THR    = 4'd2,
        A_MASK   = 4'd3,
        A_LEFT   = 4'd4,
        A_RIGHT  = 4'd5,
        A_FLUSH  = 4'd6,
        A_STAT   = 4'd7,
        A_OVRCLR = 4'd8
    } reg_addr_e;

    // Four enables; glob_en is bit 0.
    typedef struct packed {
        logic pair_en;
        logic clk_en;
        logic blk_en;
        logic glob_en;
    } gate_t;

    // Serial clocks per word-select half-period.
    function automatic logic [LEN_W-1:0] slot_bits(input logic [1:0] code);
        case (code)
            2'd0:    return LEN_W'(16);
            2'd1:    return LEN_W'(24);
            default: return LEN_W'(32);
        endcase
    endfunction

    // Valid sample bits; unlisted codes fall back to 16.
    function automatic logic [LEN_W-1:0] res_bits(input logic [2:0] code);
        case (code)
            3'd4:    return LEN_W'(24);
            3'd5:    return LEN_W'(32);
            default: return LEN_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
// Frame FIFO: holds left/right pairs between the register port and the serializer.
// Assumes push is ignored when full and pop is ignored when empty; flush wins over both.
module i2s_tx_fifo #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (level == '0);
    assign full     = (level == LVL_W'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

    // Pointer and level bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/i2s_tx_serializer.sv
// I2S shifter: toggles the serial clock on each bclk_en and changes data on falling edges.
// It pops one frame at every left-slot start, or sends zeros if the FIFO is empty.
// Assumes slot_len is at least 16 and res_len is at most DATA_W.
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                bclk_en,
    input  logic [LEN_W-1:0]    slot_len,
    input  logic [LEN_W-1:0]    res_len,
    input  logic                fifo_empty,
    input  logic [2*DATA_W-1:0] fifo_data,
    output logic                fifo_pop,
    output logic                sclk,
    output logic                ws,
    output logic                sd
);

    logic [LEN_W-1:0]  pos;
    logic              started;
    logic [DATA_W-1:0] cur_l, cur_r;
    logic              fall, frame_start, half_end;

    // Sample bit at slot position p (p = 0 is the word-select edge).
    function automatic logic pick(input logic [DATA_W-1:0] w, input logic [LEN_W-1:0] p,
                                  input logic [LEN_W-1:0] res);
        logic [LEN_W-1:0] idx;
        idx = res - p;
        if (p != '0 && p <= res) return w[idx[IDX_W-1:0]];
        return 1'b0;
    endfunction

    // Bit that spills into the next slot's first position when the sample fills the slot.
    function automatic logic tail(input logic [DATA_W-1:0] w, input logic [LEN_W-1:0] res,
                                  input logic [LEN_W-1:0] slot);
        logic [LEN_W-1:0] idx;
        idx = res - slot;
        if (res >= slot) return w[idx[IDX_W-1:0]];
        return 1'b0;
    endfunction

    assign fall        = run && bclk_en && sclk;
    assign half_end    = (pos >= slot_len - 1'b1);
    assign frame_start = !started || (ws && half_end);
    assign fifo_pop    = fall && frame_start && !fifo_empty;

    // Serial clock, slot position, word select and data generation.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sclk    <= 1'b0;
            ws      <= 1'b0;
            sd      <= 1'b0;
            pos     <= '0;
            started <= 1'b0;
            cur_l   <= '0;
            cur_r   <= '0;
        end else if (bclk_en) begin
            sclk <= !sclk;
            if (sclk) begin
                if (frame_start) begin
                    started <= 1'b1;
                    pos     <= '0;
                    ws      <= 1'b0;
                    sd      <= started ? tail(cur_r, res_len, slot_len) : 1'b0;
                    if (!fifo_empty) {cur_l, cur_r} <= fifo_data;
                    else begin
                        cur_l <= '0;
                        cur_r <= '0;
                    end
                end else if (half_end) begin
                    pos <= '0;
                    ws  <= 1'b1;
                    sd  <= tail(cur_l, res_len, slot_len);
                end else begin
                    pos <= pos + 1'b1;
                    sd  <= pick(ws ? cur_r : cur_l, pos + 1'b1, res_len);
                end
            end
        end
    end

endmodule

// File: rtl/i2s_tx_regs.sv
// Register port: enables, format, threshold, masks, holding registers, flush and interrupts.
// Assumes single-cycle strobes; a read of the overrun-clear address clears the sticky flag.
module i2s_tx_regs
    import i2s_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LVL_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [LVL_W-1:0]    fifo_level,
    input  logic                fifo_full,
    output gate_t               gate,
    output logic [1:0]          slot_code,
    output logic [2:0]          res_code,
    output logic                push,
    output logic [2*DATA_W-1:0] push_frame,
    output logic                flush,
    output logic                ovr,
    output logic                ovr_clr,
    output logic [1:0]          irq_mask,
    output logic                irq
);

    logic [DATA_W-1:0] hold_l;
    logic [LVL_W-1:0]  thresh;
    logic              thr_hit;

    assign push       = wr_en && (addr == A_RIGHT);
    assign push_frame = {hold_l, wdata};
    assign flush      = wr_en && (addr == A_FLUSH) && wdata[0];
    assign ovr_clr    = rd_en && (addr == A_OVRCLR);
    assign thr_hit    = (fifo_level <= thresh);

    // Configuration and holding-register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate      <= '0;
            slot_code <= '0;
            res_code  <= '0;
            thresh    <= '0;
            irq_mask  <= 2'b11;
            hold_l    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: gate <= gate_t'(wdata[3:0]);
                A_FMT: begin
                    slot_code <= wdata[4:3];
                    res_code  <= wdata[2:0];
                end
                A_THR:  thresh   <= wdata[LVL_W-1:0];
                A_MASK: irq_mask <= wdata[5:4];
                A_LEFT: hold_l   <= wdata;
                default: ;
            endcase
        end
    end

    // Sticky overrun flag: set by a push into a full FIFO, cleared by the clear read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovr <= 1'b0;
        else if (push && fifo_full) ovr <= 1'b1;
        else if (ovr_clr)           ovr <= 1'b0;
    end

    // Registered combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (thr_hit && !irq_mask[0]) || (ovr && !irq_mask[1]);
    end

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL: rdata[3:0] = gate;
                A_FMT:  rdata[4:0] = {slot_code, res_code};
                A_THR:  rdata[LVL_W-1:0] = thresh;
                A_MASK: rdata[5:4] = irq_mask;
                A_STAT: rdata[5:4] = {ovr, thr_hit};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2s_tx_core.sv
// Top of the gated I2S transmitter: register port, frame FIFO and serializer.
// Assumes bclk_en is a single-cycle pulse at twice the wanted bit rate.
module i2s_tx_core
    import i2s_tx_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              i2s_sclk,
    output logic              i2s_ws,
    output logic              i2s_sd,
    output logic              irq
);

    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

    gate_t               gate;
    logic [1:0]          slot_code;
    logic [2:0]          res_code;
    logic                push, flush, pop, ovr, ovr_clr;
    logic [2*DATA_W-1:0] push_frame, pop_frame;
    logic                fifo_empty, fifo_full;
    logic [LVL_W-1:0]    fifo_level;
    logic [1:0]          irq_mask;
    logic                run_all;

    assign run_all = gate.glob_en && gate.blk_en && gate.clk_en && gate.pair_en;

    i2s_tx_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .fifo_level(fifo_level), .fifo_full(fifo_full),
        .gate(gate), .slot_code(slot_code), .res_code(res_code), .push(push),
        .push_frame(push_frame), .flush(flush), .ovr(ovr), .ovr_clr(ovr_clr),
        .irq_mask(irq_mask), .irq(irq)
    );

    i2s_tx_fifo #(.WIDTH(2*DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .push_data(push_frame),
        .pop(pop), .pop_data(pop_frame), .empty(fifo_empty), .full(fifo_full),
        .level(fifo_level)
    );

    i2s_tx_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .run(run_all), .bclk_en(bclk_en),
        .slot_len(slot_bits(slot_code)), .res_len(res_bits(res_code)),
        .fifo_empty(fifo_empty), .fifo_data(pop_frame), .fifo_pop(pop),
        .sclk(i2s_sclk), .ws(i2s_ws), .sd(i2s_sd)
    );

endmodule

// File: rtl/i2s_tx_core_chk.sv
// Property checker for i2s_tx_core, attached through bind.
module i2s_tx_core_chk #(
    parameter int unsigned LVL_W = 3,
    parameter int unsigned DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             sclk,
    input logic             ws,
    input logic             sd,
    input logic             push,
    input logic             full,
    input logic             flush,
    input logic             ovr,
    input logic             ovr_clr,
    input logic [1:0]       mask,
    input logic             irq,
    input logic [LVL_W-1:0] level
);

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sclk && !ws && !sd));

    // R11
    ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(ws)) |-> $fell(sclk));

    // R11
    sd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(sd)) |-> $fell(sclk));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !flush) |=> ovr);

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> !irq);

endmodule

bind i2s_tx_core i2s_tx_core_chk #(.LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_all), .sclk(i2s_sclk), .ws(i2s_ws), .sd(i2s_sd),
    .push(push), .full(fifo_full), .flush(flush), .ovr(ovr), .ovr_clr(ovr_clr),
    .mask(irq_mask), .irq(irq), .level(fifo_level)
);

// File: tb/test_i2s_tx_core.sv
// Scoreboard bench: driver pushes expected frames, monitor rebuilds frames from the serial lines.
module test_i2s_tx_core;

    localparam int A_CTRL = 0, A_FMT = 1, A_THR = 2, A_MASK = 3, A_LEFT = 4,
                   A_RIGHT = 5, A_FLUSH = 6, A_STAT = 7, A_OVRCLR = 8;

    logic        clk = 1'b0;
    logic        rst_n, bclk_en, bus_wr, bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        i2s_sclk, i2s_ws, i2s_sd, irq;

    always #4 clk = ~clk;

    i2s_tx_core i_i2s_tx_core (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .i2s_sclk(i2s_sclk), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd), .irq(irq)
    );

    int  total = 0, bad = 0;
    bit  finished = 0;
    logic [63:0] exp_q[$];
    int  slot_w = 16, res_w = 16;

    // monitor state
    bit          mon_on = 0, edge_err = 0, pad_err = 0, prev_sclk = 0, prev_ws = 0, prev_sd = 0;
    bit          last_ws = 0;
    int          skip = 2, idx = 0;
    logic [31:0] acc = '0, left_v = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] res_mask();
        return (res_w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << res_w) - 1);
    endfunction

    // Driver: writes a frame and records the expected transmitted samples.
    task automatic push_frame(input logic [31:0] l, input logic [31:0] r, input bit keep);
        wr(A_LEFT, l);
        wr(A_RIGHT, r);
        if (keep) exp_q.push_back({l & res_mask(), r & res_mask()});
    endtask

    task automatic set_fmt(input int sc, input int rc, input int sw, input int rw);
        wr(A_FMT, 32'((sc << 3) | rc));
        slot_w = sw; res_w = rw;
    endtask

    task automatic stream(input string req);
        edge_err = 0;
        mon_on = 1;
        wr(A_CTRL, 32'hF);
        wait (exp_q.size() == 0);
        repeat (2 * slot_w * 4 * 2 + 40) @(negedge clk);
        mon_on = 0;
        wr(A_CTRL, 32'h0);
        check(!edge_err, "R11", {"edge alignment ", req}, 64'(edge_err), 64'd0);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: rebuilds slots at each rising serial clock and compares finished frames.
    always @(negedge clk) begin
        if (!mon_on) begin
            skip = 2; idx = 0; acc = '0; last_ws = 0; pad_err = 0;
        end else begin
            if ((i2s_ws != prev_ws || i2s_sd != prev_sd) && !(prev_sclk && !i2s_sclk))
                edge_err = 1;
            if (!prev_sclk && i2s_sclk) begin
                if (skip > 0) begin
                    skip--;
                    if (skip == 0) begin idx = 1; acc = '0; last_ws = 0; end
                end else if (i2s_ws != last_ws) begin
                    if (res_w >= slot_w) acc = {acc[30:0], i2s_sd};
                    check(idx == slot_w, "R2", "slot length", 64'(idx), 64'(slot_w));
                    check(!pad_err, "R4", "zero padding", 64'(pad_err), 64'd0);
                    if (last_ws == 1'b0) left_v = acc;
                    else begin
                        if (exp_q.size() > 0) begin
                            logic [63:0] e;
                            e = exp_q.pop_front();
                            check({left_v, acc} == e, "R5", "frame R3 R4", {left_v, acc}, e);
                        end else
                            check({left_v, acc} == 64'd0, "R6", "empty-FIFO frame",
                                  {left_v, acc}, 64'd0);
                    end
                    acc = '0; idx = 1; pad_err = 0; last_ws = i2s_ws;
                end else begin
                    if (idx <= res_w) acc = {acc[30:0], i2s_sd};
                    else if (i2s_sd) pad_err = 1;
                    idx++;
                end
            end
        end
        prev_sclk = i2s_sclk; prev_ws = i2s_ws; prev_sd = i2s_sd;
    end

    // Bit-clock pulse source: one pulse every second cycle.
    initial begin
        bclk_en = 1'b0;
        forever begin
            @(negedge clk);
            bclk_en = ~bclk_en;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int rises;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check(i2s_sclk == 0 && i2s_ws == 0 && i2s_sd == 0, "R1", "reset lines",
              {i2s_sclk, i2s_ws, i2s_sd}, 0);
        check(irq == 0, "R9", "reset irq", irq, 0);
        rd(A_MASK, v);
        check(v == 32'h30, "R9", "reset mask", v, 32'h30);
        rd(A_CTRL, v);
        check(v == 0, "R1", "reset control", v, 0);

        // R1: each enable alone missing keeps the lines quiet
        for (int i = 0; i < 4; i++) begin
            wr(A_CTRL, 32'hF & ~(32'd1 << i));
            rises = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (i2s_sclk || i2s_ws || i2s_sd) rises++;
            end
            check(rises == 0, "R1", "gate bit missing", rises, 0);
        end
        // R11: all enables set, rises at one per two pulses
        wr(A_CTRL, 32'hF);
        rises = 0;
        for (int c = 0; c < 80; c++) begin
            logic p;
            p = i2s_sclk;
            @(negedge clk);
            if (!p && i2s_sclk) rises++;
        end
        check(rises >= 19 && rises <= 21, "R11", "sclk rate", rises, 20);
        wr(A_CTRL, 32'h0);
        repeat (4) @(negedge clk);

        // R7/R9: overrun with 16-bit samples in 16-clock slots
        set_fmt(0, 2, 16, 16);
        wr(A_MASK, 32'h10);
        push_frame(32'h1234_A5C3, 32'h0000_0F0F, 1);
        push_frame(32'h0000_8001, 32'h0000_7FFE, 1);
        push_frame(32'h0000_FFFF, 32'h0000_0000, 1);
        push_frame(32'h0000_0001, 32'h0000_8000, 1);
        repeat (2) @(negedge clk);
        check(irq == 0, "R9", "irq before overrun", irq, 0);
        push_frame(32'h0000_DEAD, 32'h0000_BEEF, 0);
        rd(A_STAT, v);
        check(v[5] == 1, "R7", "overrun set", v[5], 1);
        repeat (2) @(negedge clk);
        check(irq == 1, "R9", "overrun irq", irq, 1);
        rd(A_OVRCLR, v);
        rd(A_STAT, v);
        check(v[5] == 0, "R7", "overrun cleared", v[5], 0);
        repeat (2) @(negedge clk);
        check(irq == 0, "R9", "irq after clear", irq, 0);
        stream("16/16");

        // R8: threshold 2
        wr(A_THR, 32'd2);
        wr(A_MASK, 32'h20);
        set_fmt(2, 4, 32, 24);
        repeat (2) @(negedge clk);
        check(irq == 1, "R8", "empty-threshold irq", irq, 1);
        push_frame(32'hAB12_3456, 32'h00FE_DCBA, 1);
        push_frame(32'h0080_0001, 32'h007F_FFFF, 1);
        rd(A_STAT, v);
        check(v[4] == 1, "R8", "level 2 at threshold", v[4], 1);
        push_frame(32'h0055_AA55, 32'h00C3_3C00, 1);
        rd(A_STAT, v);
        check(v[4] == 0, "R8", "level 3 above threshold", v[4], 0);
        repeat (2) @(negedge clk);
        check(irq == 0, "R8", "irq above threshold", irq, 0);
        stream("24/32");
        rd(A_STAT, v);
        check(v[4] == 1, "R8", "drained", v[4], 1);
        wr(A_MASK, 32'h30);
        repeat (2) @(negedge clk);
        check(irq == 0, "R9", "masked irq", irq, 0);

        // R3: 32-bit samples in 32-clock slots
        set_fmt(2, 5, 32, 32);
        push_frame(32'h8000_0001, 32'h7FFF_FFFE, 1);
        push_frame(32'hC0DE_F00D, 32'h1357_9BDF, 1);
        stream("32/32");

        // R2: 16-bit samples in 24-clock slots
        set_fmt(1, 2, 24, 16);
        push_frame(32'h0000_9669, 32'h0000_0180, 1);
        stream("16/24");

        // R10: flush
        wr(A_THR, 32'd0);
        set_fmt(0, 2, 16, 16);
        push_frame(32'h0000_1111, 32'h0000_2222, 0);
        push_frame(32'h0000_3333, 32'h0000_4444, 0);
        rd(A_STAT, v);
        check(v[4] == 0, "R10", "not empty before flush", v[4], 0);
        wr(A_FLUSH, 32'd1);
        rd(A_STAT, v);
        check(v[4] == 1, "R10", "empty after flush", v[4], 1);
        stream("flush R10 R6");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule